// File: doc/BRIEF.md
# Three-wire serial EEPROM command master

This block drives a three-wire serial EEPROM (chip select, serial clock, data toward the memory, data back from the memory). A host issues one operation at a time on a small command port: read a word, write a word, write-enable, write-disable, or one of three protection-register sequences (enable, clear, set). The block turns each operation into a fixed series of serial frames. Between frames it inserts a deselect gap. After any programming frame it holds select alone and watches the returned data line until the memory reports ready.

Every serial phase lasts `div_i + 1` clock cycles, so one netlist can serve memories of different speeds. The ready poll is bounded by `poll_limit_i` phases. When the poll runs out, the operation is marked failed, but the closing frames are still sent. The host sees a one-cycle `done_o` pulse at the end of each operation, `error_o` beside it, and the last read word on `rdata_o`.

Top module: `uwire_eeprom_master`

## Requirements
- R1: Read (op code 0) sends an 11-bit header MSB first: 1, then 1,0, then the 8 address bits from MSB to LSB. Select stays high while 16 data clocks follow. `rdata_o` receives the returned bits with the first bit in bit 15.
- R2: Write (op code 1) sends these in order: a write-enable frame; a 27-bit frame 1,0,1, address (8 bits MSB first), data (16 bits MSB first); a ready poll; a write-disable frame.
- R3: The write-enable frame is 1,0,0 followed by eight 1 bits. The write-disable frame is 1 followed by ten 0 bits. Op code 2 sends only the write-enable frame. Op codes 3 and 7 send only the write-disable frame.
- R4: Every transmitted bit spans three phases of `div_i`+1 cycles each, with select and `dout_en_o` high. The serial clock is low, then high, then low, and `di_o` holds the bit in all three phases. A frame of N bits therefore keeps select high for 3·N·(`div_i`+1) cycles.
- R5: Each of the 16 read data bits spans two phases: clock high, then clock low. The returned bit is sampled at the end of the high phase, and `dout_en_o` is low. A read keeps select high for 65·(`div_i`+1) cycles.
- R6: Consecutive frames and polls within one operation are separated by exactly one phase with select low.
- R7: A ready poll holds select high with clock, data and protection lines low. It ends at the first phase end where the returned bit is 1.
- R8: When `poll_limit_i` poll phases pass without ready, the poll ends and `error_o` is raised with `done_o`. A limit of 0 acts like a limit of 1. The deselect and any remaining frames (the write-disable frame for a write) still follow.
- R9: Op code 4 sends write-enable, then the write-enable pattern with `pe_o` high. Op code 5 sends the same two frames, then eleven 1 bits with `pe_o` high, then a ready poll. Op code 6 sends the same two frames, then 1,0,1 and eight 0 bits with `pe_o` high, then a ready poll. `pe_o` is low outside those frames.
- R10: `req_ready_o` is high only when idle, and a request is taken only then. `done_o` is a single-cycle pulse. `error_o` is high only together with `done_o`, and only after a poll timeout.
- R11: During reset, select, clock, data, protection and `done_o` are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Phase length minus one, in clock cycles |
| poll_limit_i | input | POLL_W | Maximum number of ready-poll phases |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | 8 | Word address |
| req_wdata_i | input | 16 | Word to program |
| req_ready_o | output | 1 | Idle, request accepted |
| done_o | output | 1 | Operation finished, one cycle |
| error_o | output | 1 | Ready-poll timeout, valid with done_o |
| rdata_o | output | 16 | Last word read |
| cs_o | output | 1 | Chip select |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data toward the memory |
| dout_en_o | output | 1 | Transmit phase marker |
| pe_o | output | 1 | Protection-register enable line |
| do_i | input | 1 | Serial data / ready from the memory |

## Verification
The bench keeps the default widths but sweeps the divider over 0, 1 and 2. This lets it check every frame's select-high time and every inter-frame gap as an exact cycle count derived from the phase length. It uses poll limits of 200, 4 and 0 against a responder that is either briefly busy or stuck busy. That covers the normal ready exit, the timeout after an exact number of phases, and the zero-limit corner. The responder decodes every frame bit by bit, so framing, opcode, address, data and protection-line usage are compared against patterns the bench builds from the requirements.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
  localparam int FRAME_W = 27;
  localparam int HDR_W   = 11;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = 16;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_WRITE = 3'd1, OP_WEN = 3'd2, OP_WDS = 3'd3,
    OP_PR_EN = 3'd4, OP_PR_CLR = 3'd5, OP_PR_SET = 3'd6, OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_RX, S_POLL, S_GAP} st_e;

  typedef struct packed {
    logic             poll;
    logic             rd;
    logic             pe;
    logic             last;
    logic [LEN_W-1:0] len;
    logic [FRAME_W-1:0] bits;  // left aligned, first bit at FRAME_W-1
  } step_t;

  localparam logic [HDR_W-1:0] PAT_WEN  = 11'b100_1111_1111;
  localparam logic [HDR_W-1:0] PAT_WDS  = 11'b100_0000_0000;
  localparam logic [HDR_W-1:0] PAT_PCLR = 11'b111_1111_1111;
  localparam logic [HDR_W-1:0] PAT_PSET = 11'b101_0000_0000;

  function automatic step_t tx_short(logic [HDR_W-1:0] p, logic pe, logic last);
    step_t s;
    s.poll = 1'b0;
    s.rd   = 1'b0;
    s.pe   = pe;
    s.last = last;
    s.len  = LEN_W'(HDR_W);
    s.bits = {p, {(FRAME_W-HDR_W){1'b0}}};
    return s;
  endfunction

  function automatic step_t poll_step(logic last);
    step_t s;
    s      = '0;
    s.poll = 1'b1;
    s.last = last;
    return s;
  endfunction
endpackage

// File: rtl/uwm_tick.sv
module uwm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/uwm_step_rom.sv
module uwm_step_rom
  import uwm_pkg::*;
(
  input  op_e               op_i,
  input  logic [1:0]        idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output step_t             step_o
);
  step_t wr_frame;

  always_comb begin
    wr_frame      = tx_short('0, 1'b0, 1'b0);
    wr_frame.len  = LEN_W'(FRAME_W);
    wr_frame.bits = {3'b101, addr_i, data_i};
  end

  always_comb begin
    step_o = tx_short(PAT_WDS, 1'b0, 1'b1);
    case (op_i)
      OP_READ: begin
        step_o    = tx_short({3'b110, addr_i}, 1'b0, 1'b1);
        step_o.rd = 1'b1;
      end
      OP_WRITE:
        case (idx_i)
          2'd0:    step_o = tx_short(PAT_WEN, 1'b0, 1'b0);
          2'd1:    step_o = wr_frame;
          2'd2:    step_o = poll_step(1'b0);
          default: step_o = tx_short(PAT_WDS, 1'b0, 1'b1);
        endcase
      OP_WEN: step_o = tx_short(PAT_WEN, 1'b0, 1'b1);
      OP_PR_EN:
        if (idx_i == 2'd0) step_o = tx_short(PAT_WEN, 1'b0, 1'b0);
        else               step_o = tx_short(PAT_WEN, 1'b1, 1'b1);
      OP_PR_CLR, OP_PR_SET:
        case (idx_i)
          2'd0:    step_o = tx_short(PAT_WEN, 1'b0, 1'b0);
          2'd1:    step_o = tx_short(PAT_WEN, 1'b1, 1'b0);
          2'd2:    step_o = tx_short((op_i == OP_PR_CLR) ? PAT_PCLR : PAT_PSET, 1'b1, 1'b0);
          default: step_o = poll_step(1'b1);
        endcase
      default: step_o = tx_short(PAT_WDS, 1'b0, 1'b1);
    endcase
  end
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
  import uwm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              error_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              dout_en_o,
  output logic              pe_o,
  input  logic              do_i
);
  localparam int LOOKAHEAD = 2;

  st_e               st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [1:0]        step_q, ph_q;
  logic [LEN_W-1:0]  bit_q, bit_idx;
  logic [POLL_W-1:0] poll_cnt_q;
  logic              err_q, done_q, tick, accept, poll_expired;
  step_t             step_w [LOOKAHEAD];
  step_t             cur, nxt;

  assign accept = req_valid_i && (st_q == S_IDLE);

  uwm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .div_i(div_i), .tick_o(tick)
  );

  // current step and the one after it
  for (genvar g = 0; g < LOOKAHEAD; g++) begin : g_rom
    uwm_step_rom u_rom (
      .op_i(op_q), .idx_i(step_q + 2'(g)), .addr_i(addr_q),
      .data_i(wdata_q), .step_o(step_w[g])
    );
  end
  assign cur = step_w[0];
  assign nxt = step_w[1];

  assign bit_idx      = LEN_W'(FRAME_W - 1) - bit_q;
  assign poll_expired = ({1'b0, poll_cnt_q} + (POLL_W+1)'(1)) >= {1'b0, poll_limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      op_q       <= OP_READ;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      step_q     <= '0;
      ph_q       <= '0;
      bit_q      <= '0;
      poll_cnt_q <= '0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE:
          if (accept) begin
            op_q    <= op_e'(req_op_i);
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            step_q  <= '0;
            bit_q   <= '0;
            ph_q    <= '0;
            err_q   <= 1'b0;
            st_q    <= S_TX;
          end
        S_TX:
          if (tick) begin
            if (ph_q != 2'd2) ph_q <= ph_q + 2'd1;
            else begin
              ph_q <= '0;
              if (bit_q == cur.len - LEN_W'(1)) begin
                bit_q <= '0;
                st_q  <= cur.rd ? S_RX : S_GAP;
              end else bit_q <= bit_q + LEN_W'(1);
            end
          end
        S_RX:
          if (tick) begin
            if (ph_q == 2'd0) begin
              rdata_q <= {rdata_q[WORD_W-2:0], do_i};
              ph_q    <= 2'd1;
            end else begin
              ph_q <= '0;
              if (bit_q == LEN_W'(WORD_W - 1)) st_q <= S_GAP;
              else bit_q <= bit_q + LEN_W'(1);
            end
          end
        S_POLL:
          if (tick) begin
            if (do_i) st_q <= S_GAP;
            else if (poll_expired) begin
              err_q <= 1'b1;
              st_q  <= S_GAP;
            end else poll_cnt_q <= poll_cnt_q + POLL_W'(1);
          end
        S_GAP:
          if (tick) begin
            if (cur.last) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              step_q     <= step_q + 2'd1;
              bit_q      <= '0;
              ph_q       <= '0;
              poll_cnt_q <= '0;
              st_q       <= nxt.poll ? S_POLL : S_TX;
            end
          end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cs_o        = (st_q == S_TX) || (st_q == S_RX) || (st_q == S_POLL);
  assign sk_o        = ((st_q == S_TX) && (ph_q == 2'd1)) || ((st_q == S_RX) && (ph_q == 2'd0));
  assign di_o        = (st_q == S_TX) && cur.bits[bit_idx];
  assign dout_en_o   = (st_q == S_TX);
  assign pe_o        = (st_q == S_TX) && cur.pe;
  assign req_ready_o = (st_q == S_IDLE);
  assign done_o      = done_q;
  assign error_o     = done_q && err_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/uwm_checker.sv
module uwm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_o,
  input logic sk_o,
  input logic di_o,
  input logic dout_en_o,
  input logic pe_o,
  input logic req_ready_o,
  input logic done_o,
  input logic error_o
);
  assert_sk_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);
  assert_di_hold_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sk_o) && dout_en_o) |-> $stable(di_o));
  assert_di_hold_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sk_o) && dout_en_o) |-> $stable(di_o));
  assert_pe_in_tx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_o |-> (cs_o && dout_en_o));
  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_no_select_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cs_o);
endmodule

bind uwire_eeprom_master uwm_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o),
  .dout_en_o(dout_en_o), .pe_o(pe_o), .req_ready_o(req_ready_o),
  .done_o(done_o), .error_o(error_o)
);

// File: tb/sim_uwire_eeprom_master.sv
module sim_uwire_eeprom_master;
  logic clk = 1'b0;
  always #2.5ns clk = ~clk;

  logic        rst_n, req_valid, do_r;
  logic [7:0]  div, req_addr;
  logic [15:0] limit, req_wdata, rdata;
  logic [2:0]  req_op;
  logic        req_ready, done, error, cs, sk, di, oe, pe;

  uwire_eeprom_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .poll_limit_i(limit),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .done_o(done),
    .error_o(error), .rdata_o(rdata), .cs_o(cs), .sk_o(sk), .di_o(di),
    .dout_en_o(oe), .pe_o(pe), .do_i(do_r)
  );

  int checks = 0, errors = 0, cyc_tot = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_tot++;
    if (cyc_tot > 190000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_tot, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors + 1);
      $finish;
    end
  end

  // ---------------- responder ----------------
  logic [15:0] mem [256];
  logic [26:0] sh;
  logic [7:0]  raddr;
  int nb = 0, k = 0, busy = 0, cyc_r = 0, gap_r = 0, g_start = 0, nfr = 0;
  bit dmode = 0, wen = 0, stuck = 0, pa = 1, po = 0, sk_p = 0, cs_p = 0;
  int fr_len [512];
  logic [26:0] fr_bits [512];
  bit fr_pa [512], fr_po [512];
  int fr_cyc [512], fr_gap [512];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5a3c;
    do_r = 1'b0;
  end

  always @(negedge clk) begin
    if (cs && !cs_p) begin
      g_start = gap_r; gap_r = 0; cyc_r = 0; nb = 0; sh = '0; pa = 1; po = 0; dmode = 0;
    end
    if (cs) begin
      cyc_r++;
      if (sk && !sk_p && !dmode && nb < 27) begin
        sh = {sh[25:0], di}; nb++; pa = pa & pe; po = po | pe;
        if (nb == 11 && sh[10:8] == 3'b110) begin dmode = 1; k = -1; raddr = sh[7:0]; end
      end
      if (!sk && sk_p && dmode) k++;
    end
    if (!cs && cs_p) begin
      if (nfr < 512) begin
        fr_len[nfr] = nb; fr_bits[nfr] = sh; fr_pa[nfr] = pa; fr_po[nfr] = po;
        fr_cyc[nfr] = cyc_r; fr_gap[nfr] = g_start; nfr++;
      end
      if (nb == 11 && !po && sh[10:0] == 11'b10011111111) wen = 1;
      if (nb == 11 && !po && sh[10:0] == 11'b10000000000) wen = 0;
      if (nb == 27 && sh[26:24] == 3'b101) begin
        if (wen) mem[sh[23:16]] = sh[15:0];
        busy = 6;
      end
      if (nb == 11 && pa && (sh[10:0] == 11'b11111111111 || sh[10:0] == 11'b10100000000)) busy = 6;
      dmode = 0;
    end
    if (!cs) gap_r++;
    if (busy > 0) busy--;
    if (dmode) do_r = (k >= 0 && k < 16) ? mem[raddr][15-k] : 1'b0;
    else       do_r = !stuck && (busy == 0);
    sk_p = sk; cs_p = cs;
  end

  // ---------------- expectations ----------------
  int exp_n;
  int exp_len [8];
  logic [26:0] exp_bits [8];
  bit exp_pe [8];

  task automatic add_exp(input int len, input logic [26:0] b, input bit p);
    exp_len[exp_n] = len; exp_bits[exp_n] = b; exp_pe[exp_n] = p; exp_n++;
  endtask

  task automatic check_frames(input int base, input int d, input string tag, input bit rd, input int poll_cyc);
    chk(nfr - base == exp_n, tag, nfr - base, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      int j;
      j = base + i;
      if (j >= nfr) break;
      chk(fr_len[j] == exp_len[i], tag, fr_len[j], exp_len[i]);
      chk(fr_bits[j] == exp_bits[i], tag, int'(fr_bits[j]), int'(exp_bits[i]));
      if (exp_len[i] > 0) begin
        chk(fr_pa[j] == exp_pe[i] && fr_po[j] == exp_pe[i], "R9 pe", int'(fr_po[j]), int'(exp_pe[i]));
        if (rd && i == 0) chk(fr_cyc[j] == 65 * (d + 1), "R5 read length", fr_cyc[j], 65 * (d + 1));
        else chk(fr_cyc[j] == 3 * exp_len[i] * (d + 1), "R4 frame length", fr_cyc[j], 3 * exp_len[i] * (d + 1));
      end else if (poll_cyc >= 0) begin
        chk(fr_cyc[j] == poll_cyc, "R8 poll length", fr_cyc[j], poll_cyc);
      end
      if (i > 0) chk(fr_gap[j] == d + 1, "R6 gap", fr_gap[j], d + 1);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [15:0] w,
                        output bit err, output logic [15:0] rd);
    int n;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = w;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 ready low while busy", int'(req_ready), 0);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(0, "R10 done timeout", n, 20000);
    err = error; rd = rdata;
    @(negedge clk);
    chk(!done && !error, "R10 done pulse", int'(done), 0);
    chk(req_ready, "R10 ready when idle", int'(req_ready), 1);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [26:0] F_WEN  = 27'b100_1111_1111;
  localparam logic [26:0] F_WDS  = 27'b100_0000_0000;
  localparam logic [26:0] F_PCLR = 27'b111_1111_1111;
  localparam logic [26:0] F_PSET = 27'b101_0000_0000;

  initial begin
    bit err;
    logic [15:0] rd, ew;
    logic [7:0] a;
    int base;
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0; div = 0; limit = 200;
    repeat (3) @(negedge clk);
    chk(!cs && !sk && !di && !pe, "R11 lines low in reset", int'({cs, sk, di, pe}), 0);
    chk(!done && !error && req_ready, "R11 handshake in reset", int'({done, error, req_ready}), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int d = 0; d < 3; d++) begin
      div = 8'(d); limit = 200; stuck = 0;
      for (int t = 0; t < 5; t++) begin
        case (t)
          0: a = 8'h00; 1: a = 8'h55; 2: a = 8'hAA; 3: a = 8'hFF; default: a = 8'(d * 37 + 9);
        endcase
        ew = mem[a];
        base = nfr; exp_n = 0; add_exp(11, {16'b0, 3'b110, a}, 0);
        run_op(3'd0, a, 16'h0, err, rd);
        chk(rd == ew, "R1 read data", rd, ew);
        chk(!err, "R10 no error on read", int'(err), 0);
        check_frames(base, d, "R1 header", 1, -1);
      end
      // write then read back
      a = 8'(8'h10 + d * 5); ew = 16'hA5C3 ^ 16'(d * 16'h1111);
      base = nfr; exp_n = 0;
      add_exp(11, F_WEN, 0); add_exp(27, {3'b101, a, ew}, 0); add_exp(0, 27'b0, 0); add_exp(11, F_WDS, 0);
      run_op(3'd1, a, ew, err, rd);
      chk(!err, "R7 poll ends on ready", int'(err), 0);
      check_frames(base, d, "R2 write sequence", 0, -1);
      base = nfr; exp_n = 0; add_exp(11, {16'b0, 3'b110, a}, 0);
      run_op(3'd0, a, 16'h0, err, rd);
      chk(rd == ew, "R2 read back", rd, ew);
      // single frames
      base = nfr; exp_n = 0; add_exp(11, F_WEN, 0);
      run_op(3'd2, 8'h33, 16'hFFFF, err, rd);
      check_frames(base, d, "R3 write-enable", 0, -1);
      base = nfr; exp_n = 0; add_exp(11, F_WDS, 0);
      run_op(3'd3, 8'hCC, 16'hFFFF, err, rd);
      check_frames(base, d, "R3 write-disable", 0, -1);
      base = nfr; exp_n = 0; add_exp(11, F_WDS, 0);
      run_op(3'd7, 8'h3C, 16'h1234, err, rd);
      check_frames(base, d, "R3 code 7", 0, -1);
      // protection sequences
      base = nfr; exp_n = 0; add_exp(11, F_WEN, 0); add_exp(11, F_WEN, 1);
      run_op(3'd4, 8'h00, 16'h0, err, rd);
      check_frames(base, d, "R9 protect enable", 0, -1);
      base = nfr; exp_n = 0; add_exp(11, F_WEN, 0); add_exp(11, F_WEN, 1);
      add_exp(11, F_PCLR, 1); add_exp(0, 27'b0, 0);
      run_op(3'd5, 8'h00, 16'h0, err, rd);
      chk(!err, "R9 clear no error", int'(err), 0);
      check_frames(base, d, "R9 protect clear", 0, -1);
      base = nfr; exp_n = 0; add_exp(11, F_WEN, 0); add_exp(11, F_WEN, 1);
      add_exp(11, F_PSET, 1); add_exp(0, 27'b0, 0);
      run_op(3'd6, 8'h00, 16'h0, err, rd);
      chk(!err, "R9 set no error", int'(err), 0);
      check_frames(base, d, "R9 protect set", 0, -1);
      // timeout on a stuck memory
      stuck = 1; limit = 4;
      a = 8'(8'h80 + d); ew = 16'h0F0F + 16'(d);
      base = nfr; exp_n = 0;
      add_exp(11, F_WEN, 0); add_exp(27, {3'b101, a, ew}, 0); add_exp(0, 27'b0, 0); add_exp(11, F_WDS, 0);
      run_op(3'd1, a, ew, err, rd);
      chk(err, "R8 timeout error", int'(err), 1);
      check_frames(base, d, "R8 frames after timeout", 0, 4 * (d + 1));
      if (d == 0) begin
        limit = 0;
        base = nfr; exp_n = 0; add_exp(11, F_WEN, 0); add_exp(11, F_WEN, 1);
        add_exp(11, F_PSET, 1); add_exp(0, 27'b0, 0);
        run_op(3'd6, 8'h00, 16'h0, err, rd);
        chk(err, "R8 zero limit error", int'(err), 1);
        check_frames(base, d, "R8 zero limit", 0, d + 1);
      end
      stuck = 0; limit = 200;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule